// File: doc/BRIEF.md
# Eight-Step Tone Sequencer Core

This block stores a looping pattern of eight steps. Each step holds a 3-bit tone code, where code 0 means silence for the audio stage that follows. The user picks a tone with an increment press, which steps an edit counter through its eight values. To copy that tone into steps, the user raises the switches of those steps while the save level is high.

A play/pause press flips the block between running and frozen. While it runs, every beat-tick strobe moves the beat position to the next step, and the position wraps after the last step. The block drives a one-hot LED vector that marks the sounding step. It also outputs the tone code of that step, and it keeps doing so while frozen. A clear level wipes every step back to silence.

Debouncing, beat-rate division, display decoding and tone synthesis sit outside this core. The reset is asynchronous and active low, and the core releases it synchronously inside.

Top module: `step_seq_core`

## Requirements
- R1: Two clock edges after reset is released, edit_tone is 0, beat_led is 8'b0000_0001, play_tone is 0 and the block is paused, so beat ticks do not move beat_led.
- R2: Each low-to-high change of tone_inc, as sampled on the clock, adds exactly one to edit_tone. Holding tone_inc high does not add more.
- R3: edit_tone wraps from 7 back to 0 on the next increment.
- R4: Each low-to-high change of play_press flips the play/pause state once. Holding play_press high causes no further flip.
- R5: The beat position advances by one on a clock edge with beat_tick high only while playing, and wraps from 7 to 0. While paused it holds.
- R6: beat_led always has exactly one bit set, and bit k is set when the beat position is k.
- R7: On every clock edge where save_lvl is high and step_sw[k] is high, step k loads the value edit_tone had before that edge. Several steps may load on the same edge.
- R8: On a clock edge where clear_lvl is high, all eight steps become 0. Clear takes priority over a save on the same edge.
- R9: play_tone equals the code stored in the step at the current beat position, whether playing or paused.
- R10: A step whose switch is low, or any step while save_lvl is low, keeps its code, unless clear_lvl is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_sw | input | 8 | Step-select switches, bit k picks step k |
| tone_inc | input | 1 | Tone increment press, acts on its rising edge |
| save_lvl | input | 1 | Save level, gated with each step switch |
| play_press | input | 1 | Play/pause press, acts on its rising edge |
| clear_lvl | input | 1 | Clear level for all steps |
| beat_tick | input | 1 | One-cycle beat strobe |
| edit_tone | output | 3 | Tone code under edit |
| beat_led | output | 8 | One-hot marker of current beat |
| play_tone | output | 3 | Tone code of the step at the beat position |

## Verification
The bench holds both presses high for several cycles. A design that counted levels instead of edges would show the edit tone running away or the beat flickering between play and pause. It drives ticks while paused and across the 7-to-0 wrap, which would expose a counter that ignores the play state or stops at the top. It raises clear and save together and saves into several steps at once. A design that gave save priority, or that decoded only one switch, would then report a wrong stored tone. It also reads the playing tone while frozen, which catches a mux that is gated by the play state.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int unsigned STEPS_DEF  = 8;
  localparam int unsigned TONE_W_DEF = 3;

  typedef enum logic {
    RUN_PAUSED  = 1'b0,
    RUN_PLAYING = 1'b1
  } run_state_e;
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ss_rise_detect.sv
module ss_rise_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
    pulse  = lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // a pulse never appears two cycles running on any lane
  genvar g;
  for (g = 0; g < N; g++) begin : g_chk
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[g] |=> !pulse[g]);
  end
endmodule

// File: rtl/ss_edit_tone.sv
module ss_edit_tone #(
  parameter int unsigned TONE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_pulse,
  output logic [TONE_W-1:0] tone
);
  logic [TONE_W-1:0] tone_q;
  logic [TONE_W-1:0] tone_d;
  logic              tone_en;

  always_comb begin
    tone_en = inc_pulse;
    tone_d  = tone_q + TONE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tone_q <= '0;
    else if (tone_en) tone_q <= tone_d;
  end

  assign tone = tone_q;

  p_edit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse |=> tone_q == TONE_W'($past(tone_q) + 1'b1));
  p_edit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_pulse |=> $stable(tone_q));
  p_edit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pulse && (&tone_q)) |=> tone_q == '0);
endmodule

// File: rtl/ss_beat_ctrl.sv
module ss_beat_ctrl
  import step_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 8,
  localparam int unsigned POS_W = $clog2(NUM_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             toggle_pulse,
  input  logic             tick,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_STEPS - 1);

  run_state_e       run_q, run_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    run_d = run_q;
    if (toggle_pulse)
      run_d = (run_q == RUN_PLAYING) ? RUN_PAUSED : RUN_PLAYING;
  end

  always_comb begin
    pos_en = tick && (run_q == RUN_PLAYING);
    pos_d  = (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= RUN_PAUSED;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos = pos_q;

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_pulse |=> run_q != $past(run_q));
  p_toggle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_pulse |=> $stable(run_q));
  p_beat_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run_q == RUN_PLAYING) |=> $stable(pos_q));
  p_beat_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q == RUN_PLAYING && pos_q == LAST_POS) |=> pos_q == '0);
endmodule

// File: rtl/ss_step_bank.sv
module ss_step_bank #(
  parameter int unsigned NUM_STEPS = 8,
  parameter int unsigned TONE_W    = 3,
  localparam int unsigned POS_W = $clog2(NUM_STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_STEPS-1:0] sel_sw,
  input  logic                 save,
  input  logic                 clr,
  input  logic [TONE_W-1:0]    din,
  input  logic [POS_W-1:0]     rd_pos,
  output logic [TONE_W-1:0]    rd_tone
);
  logic [TONE_W-1:0] step_q [NUM_STEPS];

  genvar k;
  for (k = 0; k < NUM_STEPS; k++) begin : g_step
    logic              ld_en;
    logic [TONE_W-1:0] step_d;

    always_comb begin
      ld_en  = clr || (save && sel_sw[k]);
      step_d = clr ? '0 : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     step_q[k] <= '0;
      else if (ld_en) step_q[k] <= step_d;
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> step_q[k] == '0);
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && save && sel_sw[k]) |=> step_q[k] == $past(din));
    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(save && sel_sw[k])) |=> $stable(step_q[k]));
  end

  assign rd_tone = step_q[rd_pos];
endmodule

// File: rtl/step_seq_core.sv
module step_seq_core
  import step_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = STEPS_DEF,
  parameter int unsigned TONE_W    = TONE_W_DEF,
  localparam int unsigned POS_W = $clog2(NUM_STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_STEPS-1:0] step_sw,
  input  logic                 tone_inc,
  input  logic                 save_lvl,
  input  logic                 play_press,
  input  logic                 clear_lvl,
  input  logic                 beat_tick,
  output logic [TONE_W-1:0]    edit_tone,
  output logic [NUM_STEPS-1:0] beat_led,
  output logic [TONE_W-1:0]    play_tone
);
  logic             srst_n;
  logic [1:0]       press_pulse;
  logic [POS_W-1:0] beat_pos;
  logic [TONE_W-1:0] edit_q;

  ss_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n)
  );

  ss_rise_detect #(.N(2)) u_edges (
    .clk(clk), .rst_n(srst_n),
    .lvl({play_press, tone_inc}), .pulse(press_pulse)
  );

  ss_edit_tone #(.TONE_W(TONE_W)) u_edit (
    .clk(clk), .rst_n(srst_n), .inc_pulse(press_pulse[0]), .tone(edit_q)
  );

  ss_beat_ctrl #(.NUM_STEPS(NUM_STEPS)) u_beat (
    .clk(clk), .rst_n(srst_n), .toggle_pulse(press_pulse[1]),
    .tick(beat_tick), .pos(beat_pos)
  );

  ss_step_bank #(.NUM_STEPS(NUM_STEPS), .TONE_W(TONE_W)) u_bank (
    .clk(clk), .rst_n(srst_n), .sel_sw(step_sw), .save(save_lvl),
    .clr(clear_lvl), .din(edit_q), .rd_pos(beat_pos), .rd_tone(play_tone)
  );

  always_comb begin
    beat_led           = '0;
    beat_led[beat_pos] = 1'b1;
  end

  assign edit_tone = edit_q;

  p_led_onehot_r6: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(beat_led) == 1);
  p_led_move_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !beat_tick |=> $stable(beat_led));
endmodule

// File: tb/step_seq_core_bench.sv
module step_seq_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] step_sw;
  logic       tone_inc, save_lvl, play_press, clear_lvl, beat_tick;
  logic [2:0] edit_tone, play_tone;
  logic [7:0] beat_led;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0] m_edit, m_pos;
  logic       m_play, m_pinc, m_pplay;
  logic [2:0] m_step [8];

  always #4 clk = ~clk;

  step_seq_core u_step_seq_core (
    .clk(clk), .rst_n(rst_n), .step_sw(step_sw), .tone_inc(tone_inc),
    .save_lvl(save_lvl), .play_press(play_press), .clear_lvl(clear_lvl),
    .beat_tick(beat_tick), .edit_tone(edit_tone), .beat_led(beat_led),
    .play_tone(play_tone)
  );

  function automatic logic [2:0] f_wrap_inc(logic [2:0] v);
    return (v == 3'd7) ? 3'd0 : v + 3'd1;
  endfunction

  function automatic logic [7:0] f_led(logic [2:0] p);
    return 8'b1 << p;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "edit_tone", edit_tone, m_edit);
    check(tag, "beat_led",  beat_led,  f_led(m_pos));
    check(tag, "play_tone", play_tone, m_step[m_pos]);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic inc, logic sv, logic pp, logic cl, logic tk,
                     logic [7:0] sw, string tag);
    tone_inc = inc; save_lvl = sv; play_press = pp;
    clear_lvl = cl; beat_tick = tk; step_sw = sw;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      if (cl)               m_step[k] = 3'd0;
      else if (sv && sw[k]) m_step[k] = m_edit;
    end
    if (tk && m_play) m_pos = f_wrap_inc(m_pos);
    if (inc && !m_pinc) m_edit = f_wrap_inc(m_edit);
    if (pp && !m_pplay) m_play = ~m_play;
    m_pinc = inc; m_pplay = pp;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0042));
    rst_n = 1'b0; step_sw = '0; tone_inc = 0; save_lvl = 0;
    play_press = 0; clear_lvl = 0; beat_tick = 0;
    m_edit = 0; m_pos = 0; m_play = 0; m_pinc = 0; m_pplay = 0;
    for (int k = 0; k < 8; k++) m_step[k] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // R1/R5: ticks while paused after reset do nothing
    repeat (3) cyc(0, 0, 0, 0, 1, 8'h00, "R1");

    // R2: held increment counts once
    repeat (4) cyc(1, 0, 0, 0, 0, 8'h00, "R2");
    cyc(0, 0, 0, 0, 0, 8'h00, "R2");
    // R3: seven more presses wrap 7 -> 0
    for (int i = 0; i < 7; i++) begin
      cyc(1, 0, 0, 0, 0, 8'h00, "R3");
      cyc(0, 0, 0, 0, 0, 8'h00, "R3");
    end
    cyc(1, 0, 0, 0, 0, 8'h00, "R2");
    cyc(0, 0, 0, 0, 0, 8'h00, "R2");
    cyc(1, 0, 0, 0, 0, 8'h00, "R2");
    cyc(0, 0, 0, 0, 0, 8'h00, "R2");

    // R7: save into several steps, including on an increment edge
    cyc(0, 1, 0, 0, 0, 8'b1010_0101, "R7");
    cyc(1, 1, 0, 0, 0, 8'b0000_0010, "R7");
    cyc(0, 0, 0, 0, 0, 8'h00, "R7");
    // R10: switches without save, save without switches
    cyc(0, 0, 0, 0, 0, 8'hFF, "R10");
    cyc(0, 1, 0, 0, 0, 8'h00, "R10");

    // R4: held play press flips once; R5/R6/R9: walk and wrap
    repeat (3) cyc(0, 0, 1, 0, 0, 8'h00, "R4");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 8'h00, "R5");
    cyc(0, 0, 0, 0, 0, 8'h00, "R6");
    // R4: pause, then R9 readback while frozen
    cyc(0, 0, 1, 0, 0, 8'h00, "R4");
    cyc(0, 0, 0, 0, 1, 8'h00, "R9");
    cyc(0, 1, 0, 0, 0, 8'hFF, "R9");
    cyc(0, 0, 0, 0, 1, 8'h00, "R9");

    // R8: clear wins over a simultaneous save
    cyc(0, 1, 0, 1, 0, 8'hFF, "R8");
    cyc(0, 0, 0, 0, 0, 8'h00, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 9) == 0,
          ($urandom % 40) == 0, ($urandom % 2) == 0, 8'($urandom), "R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule